// File: doc/BRIEF.md
# Watchdog and Stop-Mode Controller

This block supervises a small microcontroller core. A watchdog counter advances once per machine cycle. It issues a one-cycle CPU reset if software fails to clear it in time. Software clears it with a dedicated clear strobe, and a rising edge on the remote-control output line also clears it.

The same block runs the low-power stop mode. A stop strobe from the core turns the oscillator off and holds the core. While stopped, the remote output and the two upper port outputs are forced low. Any of eight active-low wake inputs ends the stop: the oscillator restarts and a settling count runs on the raw clock before the core resumes.

The controller has three states:
- `ST_RUN`: normal execution.
- `ST_STOP`: oscillator off.
- `ST_SETTLE`: oscillator running, core still held.

Its transitions are:
- stop accepted: RUN to STOP.
- wake seen: STOP to SETTLE.
- settling done: SETTLE to RUN.

Top module: `wdt_stop_ctrl`

## Requirements
- R1: After reset the block is in ST_RUN: osc_en=1, core_run=1, force_low=0, cpu_rst=0.
- R2: In ST_RUN the watchdog counts machine-cycle ticks. On the clock edge that registers the 8192nd tick since its last clear, it raises cpu_rst in the following cycle and restarts from zero.
- R3: A wdt_clr strobe clears the watchdog count. Clearing takes priority over a tick in the same cycle.
- R4: A rising edge of remote_lvl (low in one cycle, high in the next) clears the watchdog. A level held high does not keep clearing it.
- R5: stop_req in ST_RUN, with all wake_n bits high, moves to ST_STOP (stop accepted). In ST_STOP: osc_en=0, core_run=0, force_low=1.
- R6: stop_req in ST_RUN while any wake_n bit is low is ignored: the block stays in ST_RUN.
- R7: In ST_STOP, any wake_n bit low moves to ST_SETTLE (wake seen). In ST_SETTLE: osc_en=1, core_run=0, force_low=1. After exactly 8192 clock cycles in ST_SETTLE the block returns to ST_RUN (settling done).
- R8: The watchdog is held at zero in ST_STOP and ST_SETTLE, so it counts from zero after return to ST_RUN.
- R9: cpu_rst is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| wdt_clr | input | 1 | Watchdog clear strobe from the core |
| remote_lvl | input | 1 | Current level of the remote output line |
| stop_req | input | 1 | Stop instruction strobe |
| wake_n | input | 8 | Active-low wake inputs (keys and I/O) |
| cpu_rst | output | 1 | One-cycle watchdog reset pulse |
| osc_en | output | 1 | Oscillator enable |
| core_run | output | 1 | High when the core may execute |
| force_low | output | 1 | Forces remote output and upper port outputs low |

## Verification
The bench drives the watchdog to exactly 8192 ticks and checks that the reset lands in the cycle after the last tick. A counter that trips one tick early or late, or does not restart, would fire at the wrong cycle. A remote line held high for longer than the timeout must still trip the watchdog; a level-sensitive clear would never trip. A stop strobe with a wake input already low must leave the core running; a design missing that guard would freeze. Full stop and wake cycles check that the settling lasts exactly 8192 clocks and that the watchdog restarts from zero, against a bench model, under random ticks, clears, remote toggles and wake activity.

// File: rtl/wdt_stop_pkg.sv
package wdt_stop_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int W          = 14,
    parameter int TRIP_TICKS = 8192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         hold,
    input  logic         remote_lvl,
    output logic         trip,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TRIP_VAL = TRIP_TICKS[W-1:0];
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic         remote_q;
    logic         remote_rise;
    logic [W-1:0] cnt_inc;

    assign remote_rise = remote_lvl & ~remote_q;
    assign cnt_inc     = cnt + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remote_q <= 1'b0;
            cnt      <= '0;
            trip     <= 1'b0;
        end else begin
            remote_q <= remote_lvl;
            trip     <= 1'b0;
            if (hold || clr || remote_rise) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt_inc == TRIP_VAL) begin
                    cnt  <= '0;
                    trip <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
    parameter int SETTLE_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int          SW   = $clog2(SETTLE_CYCLES);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);
    localparam logic [SW-1:0] ONE  = {{(SW-1){1'b0}}, 1'b1};

    logic [SW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!en) cnt <= '0;
        else          cnt <= cnt + ONE;
    end

    assign done = en && (cnt == LAST);
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
    import wdt_stop_pkg::*;
#(
    parameter int N_WAKE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic [N_WAKE-1:0] wake_n,
    input  logic              settle_done,
    output ctrl_state_t       state,
    output logic              osc_en,
    output logic              core_run,
    output logic              force_low
);
    ctrl_state_t state_nx;
    logic        any_wake;

    assign any_wake = ~&wake_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (stop_req && !any_wake) state_nx = ST_STOP;
            ST_STOP:   if (any_wake)              state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done)           state_nx = ST_RUN;
            default:                              state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_RUN:    begin osc_en = 1'b1; core_run = 1'b1; force_low = 1'b0; end
            ST_STOP:   begin osc_en = 1'b0; core_run = 1'b0; force_low = 1'b1; end
            ST_SETTLE: begin osc_en = 1'b1; core_run = 1'b0; force_low = 1'b1; end
            default:   begin osc_en = 1'b1; core_run = 1'b0; force_low = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wdt_stop_ctrl.sv
module wdt_stop_ctrl
    import wdt_stop_pkg::*;
#(
    parameter int WDT_BITS      = 14,
    parameter int TRIP_TICKS    = 8192,
    parameter int SETTLE_CYCLES = 8192,
    parameter int N_WAKE        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wdt_clr,
    input  logic              remote_lvl,
    input  logic              stop_req,
    input  logic [N_WAKE-1:0] wake_n,
    output logic              cpu_rst,
    output logic              osc_en,
    output logic              core_run,
    output logic              force_low
);
    ctrl_state_t         state;
    logic                settle_done;
    logic                wdt_hold;
    logic [WDT_BITS-1:0] wdt_cnt;

    assign wdt_hold = (state != ST_RUN);

    stop_fsm #(.N_WAKE(N_WAKE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_n(wake_n),
        .settle_done(settle_done), .state(state), .osc_en(osc_en),
        .core_run(core_run), .force_low(force_low)
    );

    settle_counter #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .en(state == ST_SETTLE), .done(settle_done)
    );

    wdt_counter #(.W(WDT_BITS), .TRIP_TICKS(TRIP_TICKS)) u_wdt (
        .clk(clk), .rst_n(rst_n), .tick(mc_tick), .clr(wdt_clr),
        .hold(wdt_hold), .remote_lvl(remote_lvl), .trip(cpu_rst), .cnt(wdt_cnt)
    );
endmodule

// File: rtl/wdt_stop_chk.sv
module wdt_stop_chk #(
    parameter int CNT_W  = 14,
    parameter int N_WAKE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_req,
    input logic [N_WAKE-1:0] wake_n,
    input logic              cpu_rst,
    input logic              osc_en,
    input logic              core_run,
    input logic              force_low,
    input logic [CNT_W-1:0]  wdt_cnt
);
    logic prev_run;
    logic prev_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_run  <= 1'b1;
            prev_hold <= 1'b0;
        end else begin
            prev_run  <= core_run;
            prev_hold <= !core_run;
        end
    end

    assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |=> !cpu_rst);

    assert_rst_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst |-> prev_run);

    assert_stop_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (force_low && !core_run));

    assert_stop_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && stop_req && !(&wake_n)) |=> core_run);

    assert_wake_restarts_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !(&wake_n)) |=> osc_en);

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run && prev_hold) |-> (wdt_cnt == '0));
endmodule

bind wdt_stop_ctrl wdt_stop_chk #(.CNT_W(WDT_BITS), .N_WAKE(N_WAKE)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_n(wake_n),
    .cpu_rst(cpu_rst), .osc_en(osc_en), .core_run(core_run),
    .force_low(force_low), .wdt_cnt(wdt_cnt)
);

// File: tb/wdt_stop_ctrl_tb.sv
module wdt_stop_ctrl_tb;
    localparam int TRIP   = 8192;
    localparam int SETTLE = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0, wdt_clr = 1'b0, remote_lvl = 1'b0, stop_req = 1'b0;
    logic [7:0] wake_n = 8'hFF;
    logic       cpu_rst, osc_en, core_run, force_low;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model: 0 run, 1 stop, 2 settle
    int m_st = 0, m_cnt = 0, m_settle = 0;
    bit m_rst = 0, m_rem = 0;

    always #4 clk = ~clk;

    wdt_stop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wdt_clr(wdt_clr),
        .remote_lvl(remote_lvl), .stop_req(stop_req), .wake_n(wake_n),
        .cpu_rst(cpu_rst), .osc_en(osc_en), .core_run(core_run), .force_low(force_low)
    );

    function automatic bit exp_osc(int st);  return st != 1; endfunction
    function automatic bit exp_run(int st);  return st == 0; endfunction
    function automatic bit exp_flow(int st); return st != 0; endfunction

    task automatic model_step();
        bit rise;
        int nst;
        rise  = remote_lvl && !m_rem;
        m_rem = remote_lvl;
        m_rst = 0;
        if (m_st != 0 || wdt_clr || rise) m_cnt = 0;
        else if (mc_tick) begin
            if (m_cnt + 1 == TRIP) begin m_cnt = 0; m_rst = 1; end
            else m_cnt = m_cnt + 1;
        end
        nst = m_st;
        case (m_st)
            0: if (stop_req && (&wake_n)) nst = 1;
            1: if (!(&wake_n)) begin nst = 2; m_settle = 0; end
            default: if (m_settle == SETTLE - 1) nst = 0; else m_settle = m_settle + 1;
        endcase
        if (nst == 2 && m_st == 1) m_settle = 0;
        m_st = nst;
    endtask

    task automatic cmp(string tag, string what, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        cmp(tag, "cpu_rst", cpu_rst, m_rst);
        cmp(tag, "osc_en", osc_en, exp_osc(m_st));
        cmp(tag, "core_run", core_run, exp_run(m_st));
        cmp(tag, "force_low", force_low, exp_flow(m_st));
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle_inputs();
        mc_tick = 0; wdt_clr = 0; stop_req = 0; wake_n = 8'hFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (R1 run incomplete) actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2: full timeout, then R9 single pulse
        mc_tick = 1;
        for (int i = 0; i < TRIP; i++) cyc("R2");
        cmp("R2", "cpu_rst after timeout", cpu_rst, 1'b1);
        cyc("R9");
        cmp("R9", "cpu_rst second cycle", cpu_rst, 1'b0);

        // R3: clear in the middle, with a tick in the same cycle
        for (int i = 0; i < 5000; i++) cyc("R3");
        wdt_clr = 1; cyc("R3"); wdt_clr = 0;
        for (int i = 0; i < 5000; i++) cyc("R3");
        cmp("R3", "no early reset", cpu_rst, 1'b0);

        // R4: one rising edge clears, held high does not
        remote_lvl = 1; cyc("R4");
        for (int i = 0; i < TRIP; i++) cyc("R4");
        remote_lvl = 0; cyc("R4");

        // R6: stop with a wake input low is ignored
        wake_n = 8'hF7; stop_req = 1; cyc("R6"); stop_req = 0; wake_n = 8'hFF;
        cmp("R6", "core_run stays", core_run, 1'b1);
        cyc("R6");

        // R5/R7/R8: stop, wake, settle, restart count from zero
        stop_req = 1; cyc("R5"); stop_req = 0;
        cmp("R5", "osc_en in stop", osc_en, 1'b0);
        for (int i = 0; i < 20; i++) cyc("R8");
        wake_n = 8'hBF; cyc("R7"); wake_n = 8'hFF;
        cmp("R7", "osc_en in settle", osc_en, 1'b1);
        for (int i = 0; i < SETTLE - 1; i++) cyc("R7");
        cmp("R7", "still held before last settle cycle", core_run, 1'b0);
        cyc("R7");
        cmp("R7", "run after settle", core_run, 1'b1);
        for (int i = 0; i < TRIP; i++) cyc("R8");
        cmp("R8", "trip after fresh count", cpu_rst, 1'b1);

        // random mix
        for (int i = 0; i < 30000; i++) begin
            mc_tick    = ($urandom % 4) != 0;
            wdt_clr    = ($urandom % 6000) == 0;
            remote_lvl = (($urandom % 3000) == 0) ? ~remote_lvl : remote_lvl;
            stop_req   = ($urandom % 6000) == 0;
            wake_n     = (($urandom % 40) == 0) ? ~(8'h01 << ($urandom % 8)) : 8'hFF;
            cyc("R2");
        end
        idle_inputs();
        cyc("R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule